// File: doc/BRIEF.md
# Frame list slot sequencer

This controller keeps track of up to three list buffers for a frame-driven processing engine. The buffers are identified only by a small numeric identifier. One slot holds the buffer the engine is running this frame (active). One holds the buffer already handed to the engine for the next frame (queued). One holds a buffer that software committed while the engine had not yet taken the queued one (pending). Software offers buffers on a valid/ready commit port. The engine reports each frame end with a pulse and shows whether it still holds an untaken update. The controller answers with enqueue strobes to the engine, release strobes that return identifiers to a free pool, and a per-frame completion flag.

A continuous mode rotates the slots at every frame end and copes with a commit that races a frame end. In that mode a buffer the engine has not yet taken is held back one frame. A newer commit replaces an older waiting one instead of overwriting the queued slot. A single-shot mode hands every committed buffer straight to the engine and retires it at the next frame end. The commit port applies back-pressure only during a flush: `commit_ready` is low in a cycle where `flush` is high, and a commit offered then is not taken and must be held by the producer. In every other cycle a commit with `commit_valid` high is accepted.

Top module: `flq_ctrl`

## Requirements
- R1: After reset all three slots are empty, every output strobe and `frame_done` are low, and a flush then releases nothing.
- R2: In continuous mode, a commit accepted while no update is outstanding is enqueued to the engine. That means `enq_valid` is high with `enq_id` equal to the committed identifier. The commit becomes the queued buffer, and a previously queued buffer is released on lane 1 (`rel_valid[1]`, `rel_id[7:4]` for the default width).
- R3: In continuous mode, a commit accepted while an update is outstanding is not enqueued. It becomes the pending buffer, and a previously pending buffer is released on lane 2 (`rel_valid[2]`, `rel_id[11:8]`).
- R4: An update counts as outstanding only while the queued slot holds a buffer. With the queued slot empty, `hw_upd_pending` has no effect.
- R5: At a continuous-mode frame end with an update outstanding, no slot changes, nothing is enqueued or released, and `frame_done` stays low.
- R6: At a continuous-mode frame end with no update outstanding and a queued buffer present, the active buffer (if any) is released on lane 0 (`rel_valid[0]`, `rel_id[3:0]`). The queued buffer becomes active, the queued slot empties and `frame_done` is high.
- R7: At that continuous-mode frame end a pending buffer, if present, is enqueued to the engine and moves to the queued slot, and the pending slot empties.
- R8: In single-shot mode an accepted commit is enqueued to the engine at once and becomes the active buffer. A buffer still active is released on lane 0.
- R9: In single-shot mode every frame end releases the active buffer (if any) on lane 0, empties the active slot and raises `frame_done`.
- R10: A flush releases every occupied slot on its own lane (active 0, queued 1, pending 2) and empties all slots. A frame end in the same cycle is ignored, `commit_ready` is low, and no enqueue or `frame_done` follows.
- R11: A frame end and a commit in the same cycle are handled frame end first, then commit. A buffer enqueued by that frame end counts as an outstanding update for the commit.
- R12: All strobes and `frame_done` appear in the cycle after the inputs that cause them and last one cycle. An identifier output reads zero while its valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| single_shot | input | 1 | 1 selects single-shot mode, 0 continuous mode; change only together with a flush |
| commit_valid | input | 1 | A buffer is offered for commit |
| commit_ready | output | 1 | Commit accepted this cycle when valid is also high |
| commit_id | input | ID_W | Identifier of the offered buffer |
| frame_end | input | 1 | One-cycle frame end event from the engine |
| hw_upd_pending | input | 1 | Engine still holds an update it has not taken |
| flush | input | 1 | Release all slots and empty them |
| enq_valid | output | 1 | Strobe: hand `enq_id` to the engine |
| enq_id | output | ID_W | Identifier being enqueued |
| rel_valid | output | 3 | Release strobes, lane 0 active, 1 queued, 2 pending |
| rel_id | output | 3*ID_W | Released identifiers, lane n at bits n*ID_W upward |
| frame_done | output | 1 | The previous list completed at this frame end |

## Verification
The block is driven first through a directed walk in continuous mode. It commits with the update flag low and high, commits twice into the pending slot, and sends frame ends that are skipped, that promote with and without a pending buffer, and that find nothing queued. This separates the enqueue path from the hold-back path, and shows that the flag is ignored with an empty queued slot. A frame end and a commit in the same cycle are tried once with a pending buffer present and once without. This tells apart the frame-end-first order from its reverse. A flush of three occupied slots and a single-shot walk follow, and then a long random run of all inputs against a behavioural model of the three slots, compared every cycle.

// File: rtl/flq_pkg.sv
package flq_pkg;
  // Slot lanes; release lane n always carries the buffer of slot n.
  localparam int LANE_ACT  = 0;
  localparam int LANE_QUE  = 1;
  localparam int LANE_PEN  = 2;
  localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/flq_slot.sv
module flq_slot #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d_vld,
  input  logic [ID_W-1:0] d_id,
  output logic            q_vld,
  output logic [ID_W-1:0] q_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_id  <= '0;
    end else begin
      q_vld <= d_vld;
      q_id  <= d_id;
    end
  end
endmodule

// File: rtl/flq_next.sv
module flq_next
  import flq_pkg::*;
#(
  parameter int ID_W = 4,
  localparam int TW  = NUM_SLOTS * ID_W
) (
  input  logic                 single_shot,
  input  logic                 flush,
  input  logic                 fe,
  input  logic                 cfire,
  input  logic [ID_W-1:0]      cid,
  input  logic                 hw_upd,
  input  logic [NUM_SLOTS-1:0] cur_vld,
  input  logic [TW-1:0]        cur_id,
  output logic [NUM_SLOTS-1:0] nxt_vld,
  output logic [TW-1:0]        nxt_id,
  output logic                 enq_v,
  output logic [ID_W-1:0]      enq_i,
  output logic [NUM_SLOTS-1:0] rel_v,
  output logic [TW-1:0]        rel_i,
  output logic                 done
);
  localparam int OA = LANE_ACT * ID_W;
  localparam int OQ = LANE_QUE * ID_W;
  localparam int OP = LANE_PEN * ID_W;

  logic fe_enq;
  logic busy;

  always_comb begin
    nxt_vld = cur_vld;
    nxt_id  = cur_id;
    enq_v   = 1'b0;
    enq_i   = '0;
    rel_v   = '0;
    rel_i   = '0;
    done    = 1'b0;
    fe_enq  = 1'b0;
    busy    = 1'b0;
    if (flush) begin
      rel_v = cur_vld;
      for (int l = 0; l < NUM_SLOTS; l++) begin
        if (cur_vld[l]) rel_i[l*ID_W +: ID_W] = cur_id[l*ID_W +: ID_W];
      end
      nxt_vld = '0;
      nxt_id  = '0;
    end else begin
      // frame end is resolved before a commit of the same cycle
      if (fe) begin
        if (single_shot) begin
          if (nxt_vld[LANE_ACT]) begin
            rel_v[LANE_ACT]     = 1'b1;
            rel_i[OA +: ID_W]   = nxt_id[OA +: ID_W];
          end
          nxt_vld[LANE_ACT] = 1'b0;
          nxt_id[OA +: ID_W] = '0;
          done = 1'b1;
        end else if (!(nxt_vld[LANE_QUE] && hw_upd)) begin
          if (nxt_vld[LANE_QUE]) begin
            if (nxt_vld[LANE_ACT]) begin
              rel_v[LANE_ACT]   = 1'b1;
              rel_i[OA +: ID_W] = nxt_id[OA +: ID_W];
            end
            nxt_vld[LANE_ACT]  = 1'b1;
            nxt_id[OA +: ID_W] = nxt_id[OQ +: ID_W];
            nxt_vld[LANE_QUE]  = 1'b0;
            nxt_id[OQ +: ID_W] = '0;
            done = 1'b1;
          end
          if (nxt_vld[LANE_PEN]) begin
            enq_v  = 1'b1;
            enq_i  = nxt_id[OP +: ID_W];
            nxt_vld[LANE_QUE]  = 1'b1;
            nxt_id[OQ +: ID_W] = nxt_id[OP +: ID_W];
            nxt_vld[LANE_PEN]  = 1'b0;
            nxt_id[OP +: ID_W] = '0;
            fe_enq = 1'b1;
          end
        end
      end
      if (cfire) begin
        if (single_shot) begin
          if (nxt_vld[LANE_ACT]) begin
            rel_v[LANE_ACT]   = 1'b1;
            rel_i[OA +: ID_W] = nxt_id[OA +: ID_W];
          end
          enq_v = 1'b1;
          enq_i = cid;
          nxt_vld[LANE_ACT]  = 1'b1;
          nxt_id[OA +: ID_W] = cid;
        end else begin
          busy = nxt_vld[LANE_QUE] && (hw_upd || fe_enq);
          if (busy) begin
            if (nxt_vld[LANE_PEN]) begin
              rel_v[LANE_PEN]   = 1'b1;
              rel_i[OP +: ID_W] = nxt_id[OP +: ID_W];
            end
            nxt_vld[LANE_PEN]  = 1'b1;
            nxt_id[OP +: ID_W] = cid;
          end else begin
            if (nxt_vld[LANE_QUE]) begin
              rel_v[LANE_QUE]   = 1'b1;
              rel_i[OQ +: ID_W] = nxt_id[OQ +: ID_W];
            end
            enq_v = 1'b1;
            enq_i = cid;
            nxt_vld[LANE_QUE]  = 1'b1;
            nxt_id[OQ +: ID_W] = cid;
          end
        end
      end
    end
  end
endmodule

// File: rtl/flq_ctrl.sv
module flq_ctrl
  import flq_pkg::*;
#(
  parameter int ID_W = 4,
  localparam int TW  = NUM_SLOTS * ID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 single_shot,
  input  logic                 commit_valid,
  output logic                 commit_ready,
  input  logic [ID_W-1:0]      commit_id,
  input  logic                 frame_end,
  input  logic                 hw_upd_pending,
  input  logic                 flush,
  output logic                 enq_valid,
  output logic [ID_W-1:0]      enq_id,
  output logic [NUM_SLOTS-1:0] rel_valid,
  output logic [TW-1:0]        rel_id,
  output logic                 frame_done
);
  logic [NUM_SLOTS-1:0] cur_vld, nxt_vld;
  logic [TW-1:0]        cur_id, nxt_id;
  logic                 n_enq_v, n_done;
  logic [ID_W-1:0]      n_enq_i;
  logic [NUM_SLOTS-1:0] n_rel_v;
  logic [TW-1:0]        n_rel_i;
  logic                 cfire;

  assign commit_ready = !flush;
  assign cfire        = commit_valid && commit_ready;

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      flq_slot #(.ID_W(ID_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .d_vld (nxt_vld[g]),
        .d_id  (nxt_id[g*ID_W +: ID_W]),
        .q_vld (cur_vld[g]),
        .q_id  (cur_id[g*ID_W +: ID_W])
      );
    end
  endgenerate

  flq_next #(.ID_W(ID_W)) u_next (
    .single_shot (single_shot),
    .flush       (flush),
    .fe          (frame_end),
    .cfire       (cfire),
    .cid         (commit_id),
    .hw_upd      (hw_upd_pending),
    .cur_vld     (cur_vld),
    .cur_id      (cur_id),
    .nxt_vld     (nxt_vld),
    .nxt_id      (nxt_id),
    .enq_v       (n_enq_v),
    .enq_i       (n_enq_i),
    .rel_v       (n_rel_v),
    .rel_i       (n_rel_i),
    .done        (n_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enq_valid  <= 1'b0;
      enq_id     <= '0;
      rel_valid  <= '0;
      rel_id     <= '0;
      frame_done <= 1'b0;
    end else begin
      enq_valid  <= n_enq_v;
      enq_id     <= n_enq_i;
      rel_valid  <= n_rel_v;
      rel_id     <= n_rel_i;
      frame_done <= n_done;
    end
  end
endmodule

// File: rtl/flq_ctrl_chk.sv
module flq_ctrl_chk #(
  parameter int ID_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              single_shot,
  input logic              commit_valid,
  input logic              commit_ready,
  input logic [ID_W-1:0]   commit_id,
  input logic              frame_end,
  input logic              hw_upd_pending,
  input logic              flush,
  input logic              enq_valid,
  input logic [ID_W-1:0]   enq_id,
  input logic [2:0]        rel_valid,
  input logic              frame_done
);
  assert_flush_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !commit_ready);

  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!enq_valid && !frame_done));

  assert_done_needs_fe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !frame_done);

  assert_single_fe_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (single_shot && frame_end && !flush) |=> frame_done);

  assert_single_commit_enq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (single_shot && commit_valid && commit_ready) |=> (enq_valid && enq_id == $past(commit_id)));

  assert_cont_commit_enq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_shot && commit_valid && commit_ready && !frame_end && !hw_upd_pending)
      |=> (enq_valid && enq_id == $past(commit_id)));

  assert_skip_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_shot && frame_end && hw_upd_pending && !commit_valid && !flush)
      |=> (!enq_valid && rel_valid == 3'b000));
endmodule

bind flq_ctrl flq_ctrl_chk #(.ID_W(ID_W)) u_flq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .single_shot    (single_shot),
  .commit_valid   (commit_valid),
  .commit_ready   (commit_ready),
  .commit_id      (commit_id),
  .frame_end      (frame_end),
  .hw_upd_pending (hw_upd_pending),
  .flush          (flush),
  .enq_valid      (enq_valid),
  .enq_id         (enq_id),
  .rel_valid      (rel_valid),
  .frame_done     (frame_done)
);

// File: tb/test_flq_ctrl.sv
module test_flq_ctrl;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           single_shot = 1'b0;
  logic           commit_valid = 1'b0;
  logic           commit_ready;
  logic [W-1:0]   commit_id = '0;
  logic           frame_end = 1'b0;
  logic           hw_upd_pending = 1'b0;
  logic           flush = 1'b0;
  logic           enq_valid;
  logic [W-1:0]   enq_id;
  logic [2:0]     rel_valid;
  logic [3*W-1:0] rel_id;
  logic           frame_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model: -1 means empty
  int m_act = -1, m_que = -1, m_pen = -1;
  int e_enq;
  int e_rel[3];
  bit e_done;

  always #2.5 clk = ~clk;

  flq_ctrl #(.ID_W(W)) i_flq_ctrl (
    .clk(clk), .rst_n(rst_n), .single_shot(single_shot),
    .commit_valid(commit_valid), .commit_ready(commit_ready), .commit_id(commit_id),
    .frame_end(frame_end), .hw_upd_pending(hw_upd_pending), .flush(flush),
    .enq_valid(enq_valid), .enq_id(enq_id), .rel_valid(rel_valid),
    .rel_id(rel_id), .frame_done(frame_done)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_eval(input bit ss, input bit cv, input int cid,
                            input bit fe, input bit hw, input bit fl);
    bit just = 0;
    e_enq = -1; e_done = 0;
    foreach (e_rel[k]) e_rel[k] = -1;
    if (fl) begin
      e_rel[0] = m_act; e_rel[1] = m_que; e_rel[2] = m_pen;
      m_act = -1; m_que = -1; m_pen = -1;
    end else begin
      if (fe) begin
        if (ss) begin
          e_rel[0] = m_act; m_act = -1; e_done = 1;
        end else if (m_que < 0 || !hw) begin
          if (m_que >= 0) begin
            e_rel[0] = m_act; m_act = m_que; m_que = -1; e_done = 1;
          end
          if (m_pen >= 0) begin
            e_enq = m_pen; m_que = m_pen; m_pen = -1; just = 1;
          end
        end
      end
      if (cv) begin
        if (ss) begin
          if (m_act >= 0) e_rel[0] = m_act;
          e_enq = cid; m_act = cid;
        end else if (m_que >= 0 && (hw || just)) begin
          if (m_pen >= 0) e_rel[2] = m_pen;
          m_pen = cid;
        end else begin
          if (m_que >= 0) e_rel[1] = m_que;
          e_enq = cid; m_que = cid;
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "enq_valid", int'(enq_valid), int'(e_enq >= 0));
    chk(tag, "enq_id", int'(enq_id), (e_enq >= 0) ? e_enq : 0);
    for (int k = 0; k < 3; k++) begin
      chk(tag, $sformatf("rel_valid[%0d]", k), int'(rel_valid[k]), int'(e_rel[k] >= 0));
      chk(tag, $sformatf("rel_id lane %0d", k), int'(rel_id[k*W +: W]),
          (e_rel[k] >= 0) ? e_rel[k] : 0);
    end
    chk(tag, "frame_done", int'(frame_done), int'(e_done));
  endtask

  // called at a falling edge; applies inputs for one clock and checks the result
  task automatic step(input bit ss, input bit cv, input int cid, input bit fe,
                      input bit hw, input bit fl, input string tag);
    single_shot = ss; commit_valid = cv; commit_id = W'(cid);
    frame_end = fe; hw_upd_pending = hw; flush = fl;
    #0.5;
    chk(tag, "commit_ready", int'(commit_ready), int'(!fl));
    model_eval(ss, cv && !fl, cid, fe, hw, fl);
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    e_enq = -1; e_done = 0; foreach (e_rel[k]) e_rel[k] = -1;
    compare("R1");
    step(0, 0, 0, 0, 0, 1, "R1");           // flush of empty slots releases nothing

    // continuous mode walk
    step(0, 1, 1, 0, 0, 0, "R2");           // enqueue 1
    step(0, 1, 2, 0, 1, 0, "R3");           // held as pending
    step(0, 1, 3, 0, 1, 0, "R3");           // replaces 2, release 2 on lane 2
    step(0, 0, 0, 1, 1, 0, "R5");           // skipped frame
    step(0, 0, 0, 1, 0, 0, "R7");           // promote 1, enqueue pending 3
    step(0, 0, 0, 1, 0, 0, "R6");           // promote 3, release 1
    step(0, 0, 0, 1, 1, 0, "R4");           // nothing queued: flag ignored, no completion
    step(0, 1, 4, 0, 1, 0, "R4");           // flag ignored with empty queued slot
    step(0, 1, 5, 0, 0, 0, "R2");           // release queued 4 on lane 1
    step(0, 1, 6, 1, 0, 0, "R11");          // promote 5 then enqueue 6
    step(0, 1, 7, 0, 1, 0, "R3");           // pending 7
    step(0, 1, 8, 1, 0, 0, "R11");          // promote 6, enqueue 7, commit 8 held back
    step(0, 0, 0, 1, 0, 1, "R10");          // flush all three, frame end ignored
    step(1, 0, 0, 0, 0, 1, "R10");          // flush again releases nothing

    // single-shot walk
    step(1, 1, 9, 0, 1, 0, "R8");
    step(1, 1, 10, 0, 0, 0, "R8");          // release 9
    step(1, 0, 0, 1, 1, 0, "R9");           // release 10, done
    step(1, 0, 0, 1, 0, 0, "R9");           // done with nothing active
    step(1, 1, 11, 1, 0, 0, "R11");
    step(1, 0, 0, 1, 0, 0, "R9");

    // random run against the model
    for (int phase = 0; phase < 6; phase++) begin
      bit ss = phase[0];
      step(ss, 0, 0, 0, 0, 1, "R10");
      for (int n = 0; n < 600; n++) begin
        step(ss, ($urandom % 3) == 0, int'($urandom % 16), ($urandom % 4) == 0,
             ($urandom % 2) == 0, ($urandom % 97) == 0, "R12");
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule